// File: doc/BRIEF.md
# 100BASE-X 4B/5B Nibble Coding Layer

This block sits between a 4-bit media-independent nibble interface and an aligned 5-bit code-group stream clocked at the symbol rate. On the transmit side it turns each nibble into its 5-bit data code group. It marks the start of a frame with the delimiter pair J,K and the end with the pair T,R. It sends the error group H while the transmit error input is high inside a frame. Between frames it sends Idle.

On the receive side it looks for J followed by K. It reports that pair as two preamble nibbles, turns data code groups back into nibbles with a valid flag, and marks invalid groups with an error flag and a fixed nibble. It detects a frame that stops on Idle before the end pair. It drives a carrier indication from the first J of a frame.

Scrambling, line coding, clock recovery and symbol alignment belong to neighbouring blocks.

Top module: `pcs_nibble_codec`

## Requirements
- R1: While no frame is being sent, `tx_sym` is Idle (11111); `tx_er` has no effect outside a frame.
- R2: The first cycle with `tx_en` high emits J (11000) and the next emits K (10001), replacing the first two preamble nibbles whatever their value.
- R3: Inside a frame, nibble 0..F maps to 11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100, 11101.
- R4: A frame cycle (after K) with `tx_en` and `tx_er` high emits H (00100).
- R5: The first cycle with `tx_en` low after a frame emits T (01101), the next emits R (00111), and Idle follows.
- R6: On a received J followed by K, `rx_dv` rises with `rxd` = 0101 for two cycles, one for each delimiter group.
- R7: Inside a received frame, each data code group of R3 is returned as its nibble with `rx_dv` high and `rx_er` low.
- R8: A received group that is neither data nor a valid end pair inside a frame gives `rx_er` high, `rx_dv` high and `rxd` = 1110.
- R9: A received T followed by R ends the frame: `rx_dv`, `rx_er` and `crs` are low in the output cycle for T and after.
- R10: Idle received inside a frame before T,R gives one output cycle with `rx_dv` and `rx_er` high, `rxd` = 1110 and `crs` low. The frame is then over.
- R11: `crs` is high from the output cycle of a received J until the end pair or Idle. A J not followed by K gives one `crs` cycle without `rx_dv`.
- R12: Active-low `rst_n` forces `tx_sym` to Idle and `rxd`, `rx_dv`, `rx_er`, `crs` low, even in the middle of a frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Symbol-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmit frame enable |
| tx_er | input | 1 | Transmit error request |
| txd | input | NIB_W | Transmit nibble |
| tx_sym | output | SYM_W | Transmitted code group |
| rx_sym | input | SYM_W | Received aligned code group |
| rxd | output | NIB_W | Received nibble |
| rx_dv | output | 1 | Received nibble valid |
| rx_er | output | 1 | Received error |
| crs | output | 1 | Carrier indication |

## Verification
The transmit code group is registered once, so it is due on the first rising edge after the inputs are driven. The bench drives on a falling edge and checks on the next falling edge.

The receiver holds one code group back so that it can see the following group. The result for a group therefore appears one row later in the vector table, and each row's receive expectation describes the group presented in the row before it.

The reset checks sample right after `rst_n` falls, with no clock edge in between.

// File: rtl/pcs_codec_pkg.sv
package pcs_codec_pkg;
   localparam int unsigned CG_W = 5;
   localparam int unsigned NB_W = 4;

   localparam logic [CG_W-1:0] CG_IDLE = 5'b11111;
   localparam logic [CG_W-1:0] CG_J    = 5'b11000;
   localparam logic [CG_W-1:0] CG_K    = 5'b10001;
   localparam logic [CG_W-1:0] CG_T    = 5'b01101;
   localparam logic [CG_W-1:0] CG_R    = 5'b00111;
   localparam logic [CG_W-1:0] CG_H    = 5'b00100;

   typedef enum logic [1:0] {TXS_IDLE, TXS_K, TXS_DATA, TXS_R} tx_state_t;
   typedef enum logic [1:0] {RXS_IDLE, RXS_PRE2, RXS_FRAME} rx_state_t;

   function automatic logic [CG_W-1:0] data_code(input logic [NB_W-1:0] nib);
      logic [CG_W-1:0] c;
      case (nib)
         4'h0: c = 5'b11110;  4'h1: c = 5'b01001;
         4'h2: c = 5'b10100;  4'h3: c = 5'b10101;
         4'h4: c = 5'b01010;  4'h5: c = 5'b01011;
         4'h6: c = 5'b01110;  4'h7: c = 5'b01111;
         4'h8: c = 5'b10010;  4'h9: c = 5'b10011;
         4'hA: c = 5'b10110;  4'hB: c = 5'b10111;
         4'hC: c = 5'b11010;  4'hD: c = 5'b11011;
         4'hE: c = 5'b11100;  default: c = 5'b11101;
      endcase
      return c;
   endfunction

   // {hit, nibble}: hit is set when the group is one of the sixteen data groups
   function automatic logic [NB_W:0] data_decode(input logic [CG_W-1:0] cg);
      logic [NB_W:0] r;
      r = '0;
      for (int n = 0; n < 16; n++) begin
         if (data_code(NB_W'(n)) == cg) r = {1'b1, NB_W'(n)};
      end
      return r;
   endfunction
endpackage

// File: rtl/pcs_tx_encoder.sv
module pcs_tx_encoder
   import pcs_codec_pkg::*;
#(
   parameter int unsigned NIB_W = 4,
   parameter int unsigned SYM_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tx_en,
   input  logic             tx_er,
   input  logic [NIB_W-1:0] txd,
   output logic [SYM_W-1:0] tx_sym
);
   localparam int unsigned LUT_N = 1 << NIB_W;

   logic [SYM_W-1:0] code_lut [LUT_N];
   for (genvar n = 0; n < LUT_N; n++) begin : g_lut
      assign code_lut[n] = data_code(NIB_W'(n));
   end

   tx_state_t        st_q, st_d;
   logic [SYM_W-1:0] sym_d;

   always_comb begin
      st_d  = st_q;
      sym_d = CG_IDLE;
      unique case (st_q)
         TXS_IDLE: if (tx_en) begin
            sym_d = CG_J;
            st_d  = TXS_K;
         end
         TXS_K: begin
            sym_d = CG_K;
            st_d  = TXS_DATA;
         end
         TXS_DATA: if (!tx_en) begin
            sym_d = CG_T;
            st_d  = TXS_R;
         end else begin
            sym_d = tx_er ? CG_H : code_lut[txd];
         end
         default: begin
            sym_d = CG_R;
            st_d  = TXS_IDLE;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= TXS_IDLE;
         tx_sym <= CG_IDLE;
      end else begin
         st_q   <= st_d;
         tx_sym <= sym_d;
      end
   end

   AST_K_FOLLOWS_J: assert property (@(posedge clk) disable iff (!rst_n)
      tx_sym == CG_J |=> tx_sym == CG_K); // R2
   AST_R_FOLLOWS_T: assert property (@(posedge clk) disable iff (!rst_n)
      tx_sym == CG_T |=> tx_sym == CG_R); // R5
   AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_sym == CG_IDLE && !tx_en) |=> tx_sym == CG_IDLE); // R1
   AST_ERR_SENDS_H: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_en && tx_er && (tx_sym == CG_K || tx_sym == CG_H || data_decode(tx_sym)[NIB_W]))
      |=> tx_sym == CG_H); // R4
endmodule

// File: rtl/pcs_rx_decoder.sv
module pcs_rx_decoder
   import pcs_codec_pkg::*;
#(
   parameter int unsigned NIB_W   = 4,
   parameter int unsigned SYM_W   = 5,
   parameter logic [3:0]  ERR_NIB = 4'b1110,
   parameter logic [3:0]  PRE_NIB = 4'b0101
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SYM_W-1:0] rx_sym,
   output logic [NIB_W-1:0] rxd,
   output logic             rx_dv,
   output logic             rx_er,
   output logic             crs
);
   rx_state_t        st_q, st_d;
   logic [SYM_W-1:0] held_q;
   logic [NIB_W:0]   dec;
   logic [NIB_W-1:0] rxd_d;
   logic             dv_d, er_d, crs_d;

   assign dec = data_decode(held_q);

   always_comb begin
      st_d  = st_q;
      rxd_d = '0;
      dv_d  = 1'b0;
      er_d  = 1'b0;
      crs_d = 1'b0;
      unique case (st_q)
         RXS_IDLE: if (held_q == CG_J) begin
            crs_d = 1'b1;
            if (rx_sym == CG_K) begin
               dv_d  = 1'b1;
               rxd_d = PRE_NIB;
               st_d  = RXS_PRE2;
            end
         end
         RXS_PRE2: begin
            crs_d = 1'b1;
            dv_d  = 1'b1;
            rxd_d = PRE_NIB;
            st_d  = RXS_FRAME;
         end
         default: begin
            if (held_q == CG_T && rx_sym == CG_R) begin
               st_d = RXS_IDLE;
            end else if (held_q == CG_IDLE) begin
               dv_d  = 1'b1;
               er_d  = 1'b1;
               rxd_d = ERR_NIB;
               st_d  = RXS_IDLE;
            end else if (dec[NIB_W]) begin
               crs_d = 1'b1;
               dv_d  = 1'b1;
               rxd_d = dec[NIB_W-1:0];
            end else begin
               crs_d = 1'b1;
               dv_d  = 1'b1;
               er_d  = 1'b1;
               rxd_d = ERR_NIB;
            end
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= RXS_IDLE;
         held_q <= CG_IDLE;
         rxd    <= '0;
         rx_dv  <= 1'b0;
         rx_er  <= 1'b0;
         crs    <= 1'b0;
      end else begin
         st_q   <= st_d;
         held_q <= rx_sym;
         rxd    <= rxd_d;
         rx_dv  <= dv_d;
         rx_er  <= er_d;
         crs    <= crs_d;
      end
   end

   AST_ERR_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      rx_er |-> (rxd == ERR_NIB && rx_dv)); // R8
   AST_DV_OPENS_PRE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_dv) |-> (rxd == PRE_NIB && crs)); // R6
   AST_DV_HAS_CRS: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_dv && !rx_er) |-> crs); // R11
   AST_PREMATURE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_er && !crs) |=> !rx_dv); // R10
endmodule

// File: rtl/pcs_nibble_codec.sv
module pcs_nibble_codec #(
   parameter int unsigned NIB_W   = 4,
   parameter int unsigned SYM_W   = 5,
   parameter logic [3:0]  ERR_NIB = 4'b1110,
   parameter logic [3:0]  PRE_NIB = 4'b0101
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tx_en,
   input  logic             tx_er,
   input  logic [NIB_W-1:0] txd,
   output logic [SYM_W-1:0] tx_sym,
   input  logic [SYM_W-1:0] rx_sym,
   output logic [NIB_W-1:0] rxd,
   output logic             rx_dv,
   output logic             rx_er,
   output logic             crs
);
   if (NIB_W != 4) begin : g_bad_nib
      $error("pcs_nibble_codec: NIB_W must be 4");
   end
   if (SYM_W != NIB_W + 1) begin : g_bad_sym
      $error("pcs_nibble_codec: SYM_W must be NIB_W+1");
   end

   pcs_tx_encoder #(.NIB_W(NIB_W), .SYM_W(SYM_W)) u_tx (
      .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tx_er(tx_er),
      .txd(txd), .tx_sym(tx_sym));

   pcs_rx_decoder #(.NIB_W(NIB_W), .SYM_W(SYM_W),
                    .ERR_NIB(ERR_NIB), .PRE_NIB(PRE_NIB)) u_rx (
      .clk(clk), .rst_n(rst_n), .rx_sym(rx_sym), .rxd(rxd),
      .rx_dv(rx_dv), .rx_er(rx_er), .crs(crs));
endmodule

// File: tb/tb_pcs_nibble_codec.sv
module tb_pcs_nibble_codec;
   localparam logic [4:0] SI = 5'b11111, SJ = 5'b11000, SK = 5'b10001;
   localparam logic [4:0] ST = 5'b01101, SR = 5'b00111, SH = 5'b00100;
   localparam int NROW = 24;

   // {en, er, txd, rx_sym, exp_tx_sym, exp_crs, exp_dv, exp_er, exp_rxd}
   localparam logic [22:0] VEC [NROW] = '{
      {1'b0,1'b0,4'h0, SI,       SI,       1'b0,1'b0,1'b0,4'h0},
      {1'b1,1'b0,4'h5, SJ,       SJ,       1'b0,1'b0,1'b0,4'h0},
      {1'b1,1'b0,4'h5, SK,       SK,       1'b1,1'b1,1'b0,4'h5},
      {1'b1,1'b0,4'h5, 5'b01011, 5'b01011, 1'b1,1'b1,1'b0,4'h5},
      {1'b1,1'b0,4'hD, 5'b11011, 5'b11011, 1'b1,1'b1,1'b0,4'h5},
      {1'b1,1'b0,4'h0, SH,       5'b11110, 1'b1,1'b1,1'b0,4'hD},
      {1'b1,1'b1,4'h3, 5'b11110, SH,       1'b1,1'b1,1'b1,4'hE},
      {1'b1,1'b0,4'hF, ST,       5'b11101, 1'b1,1'b1,1'b0,4'h0},
      {1'b0,1'b0,4'h0, SR,       ST,       1'b0,1'b0,1'b0,4'h0},
      {1'b0,1'b0,4'h0, SI,       SR,       1'b0,1'b0,1'b0,4'h0},
      {1'b0,1'b1,4'h7, SJ,       SI,       1'b0,1'b0,1'b0,4'h0},
      {1'b1,1'b0,4'hA, 5'b11100, SJ,       1'b1,1'b0,1'b0,4'h0},
      {1'b1,1'b0,4'hA, SJ,       SK,       1'b0,1'b0,1'b0,4'h0},
      {1'b1,1'b0,4'hA, SK,       5'b10110, 1'b1,1'b1,1'b0,4'h5},
      {1'b0,1'b0,4'h0, 5'b10100, ST,       1'b1,1'b1,1'b0,4'h5},
      {1'b0,1'b0,4'h0, SI,       SR,       1'b1,1'b1,1'b0,4'h2},
      {1'b0,1'b0,4'h0, SI,       SI,       1'b0,1'b1,1'b1,4'hE},
      {1'b0,1'b0,4'h0, SI,       SI,       1'b0,1'b0,1'b0,4'h0},
      {1'b0,1'b0,4'h0, SJ,       SI,       1'b0,1'b0,1'b0,4'h0},
      {1'b0,1'b0,4'h0, SK,       SI,       1'b1,1'b1,1'b0,4'h5},
      {1'b0,1'b0,4'h0, ST,       SI,       1'b1,1'b1,1'b0,4'h5},
      {1'b0,1'b0,4'h0, SI,       SI,       1'b1,1'b1,1'b1,4'hE},
      {1'b0,1'b0,4'h0, SI,       SI,       1'b0,1'b1,1'b1,4'hE},
      {1'b0,1'b0,4'h0, SI,       SI,       1'b0,1'b0,1'b0,4'h0}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tx_en = 1'b0, tx_er = 1'b0;
   logic [3:0] txd = '0;
   logic [4:0] rx_sym = SI;
   logic [4:0] tx_sym;
   logic [3:0] rxd;
   logic       rx_dv, rx_er, crs;
   int         n_chk = 0, n_bad = 0;
   bit         done = 1'b0;

   always #5 clk = ~clk;

   pcs_nibble_codec dut (
      .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tx_er(tx_er), .txd(txd),
      .tx_sym(tx_sym), .rx_sym(rx_sym), .rxd(rxd), .rx_dv(rx_dv),
      .rx_er(rx_er), .crs(crs));

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic string tx_tag(input logic [4:0] s);
      if (s == SI) return "R1 tx idle";
      if (s == SJ || s == SK) return "R2 tx start pair";
      if (s == SH) return "R4 tx error group";
      if (s == ST || s == SR) return "R5 tx end pair";
      return "R3 tx data group";
   endfunction

   function automatic string rx_tag(input logic [6:0] e);
      if (e[4] && !e[6]) return "R10 rx early idle";
      if (e[4]) return "R8 rx invalid group";
      if (e[5] && e[3:0] == 4'h5) return "R6 rx start pair";
      if (e[5]) return "R7 rx data";
      if (e[6]) return "R11 rx carrier";
      return "R9 rx quiet";
   endfunction

   task automatic drive(input logic [22:0] v);
      tx_en  = v[22];
      tx_er  = v[21];
      txd    = v[20:17];
      rx_sym = v[16:12];
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R12: outputs while held in reset
      check("R12 reset tx", {3'b0, tx_sym}, {3'b0, SI});
      check("R12 reset rx", {1'b0, crs, rx_dv, rx_er, rxd}, 8'h00);
      rst_n = 1'b1;
      drive(VEC[0]);
      for (int i = 0; i < NROW; i++) begin
         @(posedge clk);
         @(negedge clk);
         check(tx_tag(VEC[i][11:7]), {3'b0, tx_sym}, {3'b0, VEC[i][11:7]});
         check(rx_tag(VEC[i][6:0]), {1'b0, crs, rx_dv, rx_er, rxd}, {1'b0, VEC[i][6:0]});
         if (i + 1 < NROW) drive(VEC[i + 1]);
      end
      // R12: reset in the middle of a frame on both paths
      tx_en = 1'b1; txd = 4'h5; rx_sym = SJ;
      @(negedge clk);
      rx_sym = SK;
      repeat (3) @(negedge clk);
      rx_sym = 5'b01001;
      @(negedge clk);
      check("R12 pre-reset frame live", {6'b0, crs, rx_dv}, 8'h03);
      rst_n = 1'b0;
      #1;
      check("R12 mid-frame reset tx", {3'b0, tx_sym}, {3'b0, SI});
      check("R12 mid-frame reset rx", {1'b0, crs, rx_dv, rx_er, rxd}, 8'h00);
      tx_en = 1'b0; rx_sym = SI;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      @(negedge clk);
      check("R1 idle after reset", {3'b0, tx_sym}, {3'b0, SI});
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule